// File: doc/BRIEF.md
# Transmit Pipe Buffer-Ready Flag Generator

This block follows the occupancy of a two-bank transmit FIFO that serves one USB endpoint pipe. It raises a sticky buffer-ready status flag whenever the CPU or a DMA channel may load more data. Each word written into the bank being filled is counted. A bank becomes committed for transmission when it fills, when software pulses a buffer-valid strobe, or when a DMA write completes. The bus side reports each finished packet with a transmit-done pulse and drains the banks in the order they were committed. Two software strobes (auto-clear and FIFO-clear) empty every bank.

The ready flag is set by several events: a switch of the pipe direction from receive to transmit, a commit while no bank holds data, and a drain or clear that happens while both banks hold data. In single-bank mode the ready flag is instead set by every commit and every drain of the single bank. A transfer-end mode bit stops the flag from being set. Software clears the flag by pulsing a write-one-to-clear input. An interrupt output is the flag gated by an enable.

Top module: `pipe_rdy_gen`

## Requirements
- R1: After reset rdy_sts, rdy_irq and bank_full are all 0 and fill_bank is 0.
- R2: When dir_tx changes from 0 to 1, rdy_sts is 1 after the next clock edge (unless xfer_end_mode is 1).
- R3: A bank is full when its word count reaches MAX_PKT_WORDS with cont_mode=0, or MAX_PKT_WORDS*BANK_PKTS with cont_mode=1. The word that fills it commits the bank: bank_full bit i (bit 0 = bank 0) is set and the count restarts. If no bank held data, rdy_sts is set.
- R4: A sw_commit or dma_done pulse commits the bank being filled, whatever its word count and including zero. If no bank held data, rdy_sts is set.
- R5: In double-buffer mode, a commit while the other bank already holds data sets bank_full to 2'b11 and does not set rdy_sts.
- R6: In double-buffer mode, tx_done empties the oldest committed bank. It sets rdy_sts only when both banks held data.
- R7: auto_clr or fifo_clr empties all banks and returns fill_bank to 0. It sets rdy_sts only in double-buffer mode with both banks holding data.
- R8: With dbl_mode=0, only bank 0 is used and fill_bank stays 0. rdy_sts is set on each commit and on each tx_done that empties bank 0.
- R9: With xfer_end_mode=1, no cause sets rdy_sts. Bank tracking is unaffected.
- R10: rdy_sts is sticky until a rdy_clr pulse, which clears it after the next edge. A set event in the same cycle as rdy_clr wins.
- R11: rdy_irq is rdy_sts AND irq_en, both taken at the same clock edge.
- R12: Word writes and commits are ignored while the bank being filled already holds data. Writes, commits and tx_done are all ignored while dir_tx=0.
- R13: Banks are filled and drained alternately. fill_bank toggles after each commit in double-buffer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_tx | input | 1 | Pipe direction, 1 = transmit |
| dbl_mode | input | 1 | Double-buffer enable |
| cont_mode | input | 1 | Continuous mode: bank full means whole bank size |
| xfer_end_mode | input | 1 | Transfer-end mode, suppresses ready flag |
| irq_en | input | 1 | Interrupt enable for this pipe |
| wr_word | input | 1 | One word written into the bank being filled |
| sw_commit | input | 1 | Software buffer-valid strobe |
| dma_done | input | 1 | DMA write-complete pulse |
| tx_done | input | 1 | Bus side finished sending the oldest bank |
| auto_clr | input | 1 | Auto-clear strobe |
| fifo_clr | input | 1 | FIFO-clear strobe |
| rdy_clr | input | 1 | Write-one-to-clear for rdy_sts |
| rdy_sts | output | 1 | Sticky buffer-ready status |
| rdy_irq | output | 1 | Gated ready interrupt |
| bank_full | output | 2 | Per-bank occupancy, bit i = bank i |
| fill_bank | output | 1 | Bank currently being filled |

## Verification
A bank occupancy error shows on bank_full one edge after the event that caused it. It also shows up as a missing or spurious rdy_sts. The "no data waiting" and "both banks waiting" conditions are decided from that occupancy, so the wrong flag appears at the next commit or drain. A word counter that is off by one commits the bank one write early or late, which the bench sees at the exact word where bank_full should change. A pointer that fails to alternate shows on fill_bank after the first commit, and shows on bank_full after the first drain.

// File: rtl/pipe_rdy_pkg.sv
package pipe_rdy_pkg;
  localparam int NBANK = 2;
  typedef logic [NBANK-1:0] bank_vec_t;

  typedef struct packed {
    logic commit;
    logic drain;
    logic clear;
    logic was_empty;
    logic was_both;
  } bank_evt_t;
endpackage

// File: rtl/bank_tracker.sv
module bank_tracker
  import pipe_rdy_pkg::*;
#(
  parameter int MAX_PKT_WORDS = 8,
  parameter int BANK_PKTS     = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tx_en,
  input  logic      dbl_mode,
  input  logic      cont_mode,
  input  logic      wr_word,
  input  logic      sw_commit,
  input  logic      dma_done,
  input  logic      tx_done,
  input  logic      clr_any,
  output bank_vec_t valid_o,
  output logic      fill_o,
  output bank_evt_t evt_o
);
  localparam int FULL_WORDS = MAX_PKT_WORDS * BANK_PKTS;
  localparam int CNT_W      = $clog2(FULL_WORDS + 1);

  bank_vec_t        valid_q, valid_n;
  logic             wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CNT_W-1:0] wcnt_q, wcnt_n, limit;
  logic             bank_free, wr_ok, fill_hit, commit, drain;

  assign limit     = cont_mode ? CNT_W'(FULL_WORDS) : CNT_W'(MAX_PKT_WORDS);
  assign bank_free = !valid_q[wptr_q];
  assign wr_ok     = tx_en && bank_free && wr_word && !clr_any;
  assign fill_hit  = wr_ok && ((wcnt_q + CNT_W'(1)) >= limit);
  assign commit    = tx_en && bank_free && !clr_any && (fill_hit || sw_commit || dma_done);
  assign drain     = tx_en && !clr_any && tx_done && valid_q[rptr_q];

  always_comb begin
    valid_n = valid_q;
    wptr_n  = wptr_q;
    rptr_n  = rptr_q;
    wcnt_n  = wcnt_q;
    if (clr_any) begin
      valid_n = '0;
      wptr_n  = 1'b0;
      rptr_n  = 1'b0;
      wcnt_n  = '0;
    end else begin
      if (commit) begin
        valid_n[wptr_q] = 1'b1;
        wptr_n          = dbl_mode ? !wptr_q : 1'b0;
        wcnt_n          = '0;
      end else if (wr_ok) begin
        wcnt_n = wcnt_q + CNT_W'(1);
      end
      if (drain) begin
        valid_n[rptr_q] = 1'b0;
        rptr_n          = dbl_mode ? !rptr_q : 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      wptr_q  <= 1'b0;
      rptr_q  <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      valid_q <= valid_n;
      wptr_q  <= wptr_n;
      rptr_q  <= rptr_n;
      wcnt_q  <= wcnt_n;
    end
  end

  assign valid_o         = valid_q;
  assign fill_o          = wptr_q;
  assign evt_o.commit    = commit;
  assign evt_o.drain     = drain;
  assign evt_o.clear     = clr_any;
  assign evt_o.was_empty = (valid_q == '0);
  assign evt_o.was_both  = (valid_q == '1);

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
    clr_any |=> (valid_q == '0 && wptr_q == 1'b0 && rptr_q == 1'b0))
    else $error("clear did not empty banks");

  assert_full_bank_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    (valid_q[wptr_q] && !clr_any) |=> ($stable(wcnt_q) && $stable(wptr_q)))
    else $error("write side moved while fill bank occupied");

  assert_single_bank_R8: assert property (@(posedge clk) disable iff (rst)
    (!dbl_mode && !valid_q[1] && !wptr_q && !rptr_q) |=> (!valid_q[1] && !wptr_q && !rptr_q))
    else $error("bank 1 touched in single-bank mode");

  assert_drain_alternates_R13: assert property (@(posedge clk) disable iff (rst)
    (tx_en && tx_done && !clr_any && dbl_mode && valid_q[rptr_q]) |=> (rptr_q != $past(rptr_q)))
    else $error("read pointer failed to alternate");

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (wcnt_q <= CNT_W'(FULL_WORDS)))
    else $error("word count beyond bank size");
endmodule

// File: rtl/rdy_event_logic.sv
module rdy_event_logic
  import pipe_rdy_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      dir_tx,
  input  logic      dbl_mode,
  input  logic      xfer_end_mode,
  input  bank_evt_t evt,
  output logic      set_rdy
);
  logic dir_q, dir_rise, cond_commit, cond_drain, cond_clear;

  always_ff @(posedge clk) begin
    if (rst) dir_q <= 1'b0;
    else     dir_q <= dir_tx;
  end

  assign dir_rise    = dir_tx && !dir_q;
  assign cond_commit = evt.commit && evt.was_empty;
  assign cond_drain  = evt.drain && (!dbl_mode || evt.was_both);
  assign cond_clear  = evt.clear && dbl_mode && evt.was_both;
  assign set_rdy     = !xfer_end_mode && (dir_rise || cond_commit || cond_drain || cond_clear);

  assert_commit_needs_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (evt.commit && !evt.was_empty && !evt.drain && !dir_rise) |-> !set_rdy)
    else $error("ready raised on commit with data waiting");
endmodule

// File: rtl/rdy_status_reg.sv
module rdy_status_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_rdy,
  input  logic rdy_clr,
  input  logic irq_en,
  output logic rdy_sts,
  output logic rdy_irq
);
  logic sts_n;

  assign sts_n = set_rdy || (rdy_sts && !rdy_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_sts <= 1'b0;
      rdy_irq <= 1'b0;
    end else begin
      rdy_sts <= sts_n;
      rdy_irq <= sts_n && irq_en;
    end
  end

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (rdy_sts && !rdy_clr) |=> rdy_sts)
    else $error("ready flag dropped without clear");

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    set_rdy |=> rdy_sts)
    else $error("set event lost");

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !rdy_irq)
    else $error("interrupt while disabled");

  assert_irq_implies_sts_R11: assert property (@(posedge clk) disable iff (rst)
    rdy_irq |-> rdy_sts)
    else $error("interrupt without status");
endmodule

// File: rtl/pipe_rdy_gen.sv
module pipe_rdy_gen
  import pipe_rdy_pkg::*;
#(
  parameter int MAX_PKT_WORDS = 8,
  parameter int BANK_PKTS     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dir_tx,
  input  logic       dbl_mode,
  input  logic       cont_mode,
  input  logic       xfer_end_mode,
  input  logic       irq_en,
  input  logic       wr_word,
  input  logic       sw_commit,
  input  logic       dma_done,
  input  logic       tx_done,
  input  logic       auto_clr,
  input  logic       fifo_clr,
  input  logic       rdy_clr,
  output logic       rdy_sts,
  output logic       rdy_irq,
  output logic [1:0] bank_full,
  output logic       fill_bank
);
  bank_vec_t valid;
  bank_evt_t evt;
  logic      set_rdy, clr_any;

  assign clr_any = auto_clr || fifo_clr;

  bank_tracker #(
    .MAX_PKT_WORDS(MAX_PKT_WORDS),
    .BANK_PKTS    (BANK_PKTS)
  ) u_banks (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (dir_tx),
    .dbl_mode (dbl_mode),
    .cont_mode(cont_mode),
    .wr_word  (wr_word),
    .sw_commit(sw_commit),
    .dma_done (dma_done),
    .tx_done  (tx_done),
    .clr_any  (clr_any),
    .valid_o  (valid),
    .fill_o   (fill_bank),
    .evt_o    (evt)
  );

  rdy_event_logic u_evt (
    .clk          (clk),
    .rst          (rst),
    .dir_tx       (dir_tx),
    .dbl_mode     (dbl_mode),
    .xfer_end_mode(xfer_end_mode),
    .evt          (evt),
    .set_rdy      (set_rdy)
  );

  rdy_status_reg u_sts (
    .clk    (clk),
    .rst    (rst),
    .set_rdy(set_rdy),
    .rdy_clr(rdy_clr),
    .irq_en (irq_en),
    .rdy_sts(rdy_sts),
    .rdy_irq(rdy_irq)
  );

  assign bank_full = valid;

  assert_xfer_end_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (xfer_end_mode && !rdy_sts) |=> !rdy_sts)
    else $error("ready raised in transfer-end mode");

  assert_dir_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (dir_tx && !$past(dir_tx) && !xfer_end_mode) |=> rdy_sts)
    else $error("direction change did not raise ready");

  assert_rx_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    (!dir_tx && !auto_clr && !fifo_clr) |=> $stable(bank_full))
    else $error("banks changed while receiving");
endmodule

// File: tb/tb_pipe_rdy_gen.sv
`timescale 1ns/1ps
module tb_pipe_rdy_gen;
  localparam int MPW = 8;
  localparam int BP  = 4;
  localparam int S_WR = 0, S_SWC = 1, S_DMA = 2, S_TXD = 3, S_ACL = 4, S_FCL = 5, S_RCL = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic dir_tx = 0, dbl_mode = 0, cont_mode = 0, xfer_end_mode = 0, irq_en = 0;
  logic wr_word = 0, sw_commit = 0, dma_done = 0, tx_done = 0;
  logic auto_clr = 0, fifo_clr = 0, rdy_clr = 0;
  logic rdy_sts, rdy_irq, fill_bank;
  logic [1:0] bank_full;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  pipe_rdy_gen #(.MAX_PKT_WORDS(MPW), .BANK_PKTS(BP)) dut (
    .clk(clk), .rst(rst), .dir_tx(dir_tx), .dbl_mode(dbl_mode), .cont_mode(cont_mode),
    .xfer_end_mode(xfer_end_mode), .irq_en(irq_en), .wr_word(wr_word), .sw_commit(sw_commit),
    .dma_done(dma_done), .tx_done(tx_done), .auto_clr(auto_clr), .fifo_clr(fifo_clr),
    .rdy_clr(rdy_clr), .rdy_sts(rdy_sts), .rdy_irq(rdy_irq), .bank_full(bank_full),
    .fill_bank(fill_bank)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [6:0] m);
    @(negedge clk);
    wr_word = m[S_WR]; sw_commit = m[S_SWC]; dma_done = m[S_DMA]; tx_done = m[S_TXD];
    auto_clr = m[S_ACL]; fifo_clr = m[S_FCL]; rdy_clr = m[S_RCL];
    @(negedge clk);
    wr_word = 0; sw_commit = 0; dma_done = 0; tx_done = 0;
    auto_clr = 0; fifo_clr = 0; rdy_clr = 0;
  endtask

  task automatic words(input int n);
    for (int i = 0; i < n; i++) strobe(7'(1 << S_WR));
  endtask

  task automatic prep(input logic dbl, input logic cont, input logic xend);
    rst = 1'b1; dir_tx = 0;
    dbl_mode = dbl; cont_mode = cont; xfer_end_mode = xend; irq_en = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    dir_tx = 1'b1;
    @(negedge clk);
    chk("R2 dir rise", int'(rdy_sts), xend ? 0 : 1);
    strobe(7'(1 << S_RCL));
    chk("R10 clear", int'(rdy_sts), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdy_sts", int'(rdy_sts), 0);
    chk("R1 rdy_irq", int'(rdy_irq), 0);
    chk("R1 bank_full", int'(bank_full), 0);
    chk("R1 fill_bank", int'(fill_bank), 0);
  endtask

  task automatic t_irq();
    prep(1, 0, 0);
    irq_en = 1'b1;
    strobe(7'(1 << S_SWC));
    chk("R11 irq on", int'(rdy_irq), 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk("R11 irq gated", int'(rdy_irq), 0);
    chk("R11 sts kept", int'(rdy_sts), 1);
  endtask

  task automatic t_fill_noncont();
    prep(1, 0, 0);
    words(MPW - 1);
    chk("R3 not full yet", int'(bank_full), 0);
    chk("R3 no rdy early", int'(rdy_sts), 0);
    words(1);
    chk("R3 bank0 full", int'(bank_full), 1);
    chk("R3 rdy on fill", int'(rdy_sts), 1);
    chk("R13 fill toggles", int'(fill_bank), 1);
    strobe(7'(1 << S_RCL));
    words(MPW);
    chk("R5 both full", int'(bank_full), 3);
    chk("R5 no rdy", int'(rdy_sts), 0);
    words(3);
    chk("R12 write ignored", int'(bank_full), 3);
    strobe(7'(1 << S_TXD));
    chk("R13 oldest drained", int'(bank_full), 2);
    chk("R6 rdy on drain", int'(rdy_sts), 1);
    strobe(7'(1 << S_RCL));
    words(MPW);
    chk("R12 ignored writes not counted", int'(bank_full), 3);
    strobe(7'(1 << S_RCL));
    strobe(7'(1 << S_TXD));
    chk("R13 second drain", int'(bank_full), 1);
    chk("R6 rdy on drain both", int'(rdy_sts), 1);
    strobe(7'(1 << S_RCL));
    strobe(7'(1 << S_TXD));
    chk("R6 last drain", int'(bank_full), 0);
    chk("R6 no rdy one bank", int'(rdy_sts), 0);
  endtask

  task automatic t_fill_cont();
    prep(1, 1, 0);
    words(MPW);
    chk("R3 cont not full at one packet", int'(bank_full), 0);
    words(MPW * BP - MPW - 1);
    chk("R3 cont one short", int'(bank_full), 0);
    words(1);
    chk("R3 cont full", int'(bank_full), 1);
    chk("R3 cont rdy", int'(rdy_sts), 1);
  endtask

  task automatic t_commit_clear();
    prep(1, 0, 0);
    strobe(7'(1 << S_SWC));
    chk("R4 zero-length commit", int'(bank_full), 1);
    chk("R4 rdy", int'(rdy_sts), 1);
    strobe(7'(1 << S_RCL));
    words(2);
    strobe(7'(1 << S_DMA));
    chk("R4 dma commit", int'(bank_full), 3);
    chk("R5 no rdy", int'(rdy_sts), 0);
    strobe(7'(1 << S_FCL));
    chk("R7 fifo clear empties", int'(bank_full), 0);
    chk("R7 fifo clear rdy", int'(rdy_sts), 1);
    strobe(7'(1 << S_RCL));
    strobe(7'(1 << S_SWC));
    strobe(7'(1 << S_RCL));
    strobe(7'(1 << S_ACL));
    chk("R7 auto clear one bank", int'(bank_full), 0);
    chk("R7 no rdy one bank", int'(rdy_sts), 0);
    chk("R7 fill reset", int'(fill_bank), 0);
    strobe(7'(1 << S_DMA));
    strobe(7'(1 << S_SWC));
    strobe(7'(1 << S_RCL));
    strobe(7'(1 << S_ACL));
    chk("R7 auto clear both rdy", int'(rdy_sts), 1);
  endtask

  task automatic t_single();
    prep(0, 0, 0);
    strobe(7'(1 << S_SWC));
    chk("R8 commit bank0", int'(bank_full), 1);
    chk("R8 fill stays 0", int'(fill_bank), 0);
    chk("R8 rdy on commit", int'(rdy_sts), 1);
    strobe(7'(1 << S_RCL));
    strobe(7'(1 << S_SWC));
    chk("R12 commit ignored", int'(bank_full), 1);
    chk("R12 no rdy", int'(rdy_sts), 0);
    strobe(7'(1 << S_TXD));
    chk("R8 drained", int'(bank_full), 0);
    chk("R8 rdy on drain", int'(rdy_sts), 1);
  endtask

  task automatic t_xend();
    prep(1, 0, 1);
    strobe(7'(1 << S_SWC));
    chk("R9 commit tracked", int'(bank_full), 1);
    chk("R9 no rdy commit", int'(rdy_sts), 0);
    strobe(7'(1 << S_SWC));
    strobe(7'(1 << S_TXD));
    chk("R9 drain tracked", int'(bank_full), 2);
    chk("R9 no rdy drain", int'(rdy_sts), 0);
    strobe(7'(1 << S_SWC));
    strobe(7'(1 << S_FCL));
    chk("R9 no rdy clear", int'(rdy_sts), 0);
  endtask

  task automatic t_sticky();
    prep(1, 0, 0);
    strobe(7'(1 << S_SWC));
    repeat (5) @(negedge clk);
    chk("R10 sticky", int'(rdy_sts), 1);
    strobe(7'(1 << S_TXD));
    strobe(7'((1 << S_SWC) | (1 << S_RCL)));
    chk("R10 set wins", int'(rdy_sts), 1);
    strobe(7'(1 << S_RCL));
    chk("R10 cleared", int'(rdy_sts), 0);
  endtask

  task automatic t_rx();
    prep(1, 0, 0);
    @(negedge clk); dir_tx = 1'b0;
    strobe(7'(1 << S_SWC));
    words(MPW);
    chk("R12 rx ignores commit", int'(bank_full), 0);
    @(negedge clk); dir_tx = 1'b1;
    @(negedge clk);
    chk("R2 re-enter tx", int'(rdy_sts), 1);
  endtask

  initial begin
    t_reset();
    t_irq();
    t_fill_noncont();
    t_fill_cont();
    t_commit_clear();
    t_single();
    t_xend();
    t_sticky();
    t_rx();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule